// File: doc/BRIEF.md
# XOR-Basis Linear Index Mapper

This block translates a hardware location into a logical two-dimensional tensor coordinate. The location has three fields: a warp field, a lane field and a register field. The result is a coordinate pair, with the minor coordinate `n` listed before the major coordinate `m`. Every bit of every location field owns one stored basis vector, which is an (n, m) pair. The result is the XOR of the basis vectors of all location bits that are set. Carry-free composition of this kind produces plain strided layouts, swizzled layouts and broadcast layouts from the same table. A basis vector of zero makes several locations produce the same coordinate.

A configuration port rewrites one basis vector per cycle. Each write names a field, a bit within that field and a new (n, m) pair. A pipelined lookup port accepts one location per cycle and returns the coordinate two cycles later, together with a valid flag. After reset the table holds a 16x16 matrix-fragment layout. The register bits step `m`. The low four lane bits step `n`. The top two lane bits step `m` by 4 and by 8. The warp bits contribute nothing.

Top module: `xor_basis_mapper`

## Requirements
- R1: After reset, a lookup of location (warp w, lane t, register r) returns n = t mod 16 and m = r + 4*(t/16), whatever the value of w.
- R2: Each lookup result is the bitwise XOR of the current basis vectors of all set location bits. The bits are indexed register bits 0..1 first, then lane bits 0..5, then warp bits 0..1.
- R3: The all-zero location always returns (0, 0).
- R4: A configuration write with `cfg_we` high replaces the basis vector that `cfg_dim` and `cfg_bit` select. The `cfg_dim` encoding is 0 for register, 1 for lane and 2 for warp. `cfg_bit` counts from the least significant bit of that field.
- R5: A write takes effect for lookups accepted on later clock edges. A lookup accepted on the same edge as the write still sees the old basis vector.
- R6: A write with `cfg_dim` = 3 is ignored. So is a write whose bit index is at or beyond the width of the selected field (2 for register, 6 for lane, 2 for warp). Neither changes any basis vector.
- R7: A lookup accepted on edge k produces `rsp_valid` and its result after edge k+2. One lookup can be accepted every cycle, and results come out in order, one per accepted request.
- R8: While `rsp_valid` is low, `rsp_n` and `rsp_m` keep their previous values.
- R9: A zero basis vector broadcasts: two locations that differ only in bits whose basis is zero return the same coordinate.
- R10: Synchronous active-high reset restores the reset basis table and clears `rsp_valid`, `rsp_n` and `rsp_m` to zero.
- R11: Basis values use the full 8-bit width of each coordinate, so any value from 0x00 to 0xFF can be stored and is returned unmodified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Basis write strobe |
| cfg_dim | input | 2 | Field select: 0 register, 1 lane, 2 warp |
| cfg_bit | input | 3 | Bit index within the selected field |
| cfg_n | input | 8 | New basis value for the n coordinate |
| cfg_m | input | 8 | New basis value for the m coordinate |
| req_valid | input | 1 | Lookup request valid |
| req_warp | input | 2 | Warp field of the location |
| req_lane | input | 6 | Lane field of the location |
| req_reg | input | 2 | Register field of the location |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_n | output | 8 | Minor coordinate of the result |
| rsp_m | output | 8 | Major coordinate of the result |

## Verification
A basis rewrite and a lookup that reads the same basis entry can arrive on the same clock edge. The bench provokes this by driving a register-bit write together with a lookup of the location that uses that bit. It then repeats the lookup alone on the next cycle. The first result must still carry the old basis vector and the second must carry the new one. The bench's reference table is updated only after it has computed the expected result for a request issued in the same cycle.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

    localparam int REG_BITS    = 2;
    localparam int LANE_BITS   = 6;
    localparam int WARP_BITS   = 2;
    localparam int LANE_N_BITS = 4;   // low lane bits that step n after reset
    localparam int COORD_W     = 8;
    localparam int NUM_DIMS    = 3;

    localparam int LOC_BITS  = REG_BITS + LANE_BITS + WARP_BITS;
    localparam int MAX_DIM_W = (LANE_BITS > REG_BITS)
                             ? ((LANE_BITS > WARP_BITS) ? LANE_BITS : WARP_BITS)
                             : ((REG_BITS > WARP_BITS) ? REG_BITS : WARP_BITS);
    localparam int BIT_IDX_W = $clog2(MAX_DIM_W);

    typedef enum logic [1:0] {
        DIM_REG  = 2'd0,
        DIM_LANE = 2'd1,
        DIM_WARP = 2'd2
    } dim_e;

    typedef struct packed {
        logic [COORD_W-1:0] n;
        logic [COORD_W-1:0] m;
    } coord_t;

    typedef struct packed {
        logic [WARP_BITS-1:0] warp;
        logic [LANE_BITS-1:0] lane;
        logic [REG_BITS-1:0]  rg;
    } loc_t;

    function automatic int dim_width(input int d);
        case (d)
            0:       return REG_BITS;
            1:       return LANE_BITS;
            default: return WARP_BITS;
        endcase
    endfunction

    function automatic int dim_offset(input int d);
        case (d)
            0:       return 0;
            1:       return REG_BITS;
            default: return REG_BITS + LANE_BITS;
        endcase
    endfunction

    // Reset layout: a 16x16 fragment with register bits and high lane bits
    // stepping m, low lane bits stepping n, and warp bits broadcasting.
    function automatic coord_t reset_basis(input int idx);
        coord_t b;
        b = '0;
        if (idx < REG_BITS)
            b.m = COORD_W'(1) << idx;
        else if (idx < REG_BITS + LANE_N_BITS)
            b.n = COORD_W'(1) << (idx - REG_BITS);
        else if (idx < REG_BITS + LANE_BITS)
            b.m = COORD_W'(1) << (idx - LANE_N_BITS);
        return b;
    endfunction

endpackage

// File: rtl/xbm_basis_table.sv
module xbm_basis_table
    import xbm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_dim,
    input  logic [BIT_IDX_W-1:0] wr_bit,
    input  coord_t               wr_val,
    output coord_t [LOC_BITS-1:0] tab_q
);

    logic wr_ok;
    int   wr_idx;

    always_comb begin
        wr_ok  = 1'b0;
        wr_idx = 0;
        case (dim_e'(wr_dim))
            DIM_REG: begin
                wr_ok  = int'(wr_bit) < REG_BITS;
                wr_idx = int'(wr_bit);
            end
            DIM_LANE: begin
                wr_ok  = int'(wr_bit) < LANE_BITS;
                wr_idx = REG_BITS + int'(wr_bit);
            end
            DIM_WARP: begin
                wr_ok  = int'(wr_bit) < WARP_BITS;
                wr_idx = REG_BITS + LANE_BITS + int'(wr_bit);
            end
            default: begin
                wr_ok  = 1'b0;
                wr_idx = 0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LOC_BITS; i++) begin
            if (rst)
                tab_q[i] <= reset_basis(i);
            else if (wr_en && wr_ok && wr_idx == i)
                tab_q[i] <= wr_val;
        end
    end

endmodule

// File: rtl/xbm_xor_fold.sv
module xbm_xor_fold
    import xbm_pkg::*;
#(
    parameter int N = 2
) (
    input  logic [N-1:0]   sel,
    input  coord_t [N-1:0] basis,
    output coord_t         acc
);

    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i])
                acc = acc ^ basis[i];
        end
    end

endmodule

// File: rtl/xor_basis_mapper.sv
module xor_basis_mapper
    import xbm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_dim,
    input  logic [BIT_IDX_W-1:0] cfg_bit,
    input  logic [COORD_W-1:0]   cfg_n,
    input  logic [COORD_W-1:0]   cfg_m,
    input  logic                 req_valid,
    input  logic [WARP_BITS-1:0] req_warp,
    input  logic [LANE_BITS-1:0] req_lane,
    input  logic [REG_BITS-1:0]  req_reg,
    output logic                 rsp_valid,
    output logic [COORD_W-1:0]   rsp_n,
    output logic [COORD_W-1:0]   rsp_m
);

    coord_t [LOC_BITS-1:0] basis;
    coord_t                wr_val;
    loc_t                  loc;
    logic [LOC_BITS-1:0]   loc_bits;

    assign wr_val   = '{n: cfg_n, m: cfg_m};
    assign loc      = '{warp: req_warp, lane: req_lane, rg: req_reg};
    assign loc_bits = loc;

    xbm_basis_table u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_dim (cfg_dim),
        .wr_bit (cfg_bit),
        .wr_val (wr_val),
        .tab_q  (basis)
    );

    // Stage 1: one partial XOR per location field.
    coord_t part_d [NUM_DIMS];

    for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
        localparam int OFF = dim_offset(d);
        localparam int W   = dim_width(d);
        xbm_xor_fold #(.N(W)) u_fold (
            .sel   (loc_bits[OFF +: W]),
            .basis (basis[OFF +: W]),
            .acc   (part_d[d])
        );
    end

    logic   s1_valid;
    coord_t s1_part [NUM_DIMS];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            for (int d = 0; d < NUM_DIMS; d++) s1_part[d] <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid)
                for (int d = 0; d < NUM_DIMS; d++) s1_part[d] <= part_d[d];
        end
    end

    // Stage 2: merge the field partials into the final coordinate.
    coord_t merged;
    coord_t rsp_q;

    always_comb begin
        merged = '0;
        for (int d = 0; d < NUM_DIMS; d++) merged = merged ^ s1_part[d];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= s1_valid;
            if (s1_valid)
                rsp_q <= merged;
        end
    end

    assign rsp_n = rsp_q.n;
    assign rsp_m = rsp_q.m;

endmodule

// File: rtl/xbm_checker.sv
module xbm_checker
    import xbm_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [WARP_BITS-1:0] req_warp,
    input logic [LANE_BITS-1:0] req_lane,
    input logic [REG_BITS-1:0]  req_reg,
    input logic                 rsp_valid,
    input logic [COORD_W-1:0]   rsp_n,
    input logic [COORD_W-1:0]   rsp_m
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

    // R3
    zero_loc_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && rsp_valid &&
         $past({req_warp, req_lane, req_reg}, 2) == '0)
        |-> (rsp_n == '0 && rsp_m == '0));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !rsp_valid) |-> ($stable(rsp_n) && $stable(rsp_m)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!rsp_valid && rsp_n == '0 && rsp_m == '0));

endmodule

bind xor_basis_mapper xbm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_warp  (req_warp),
    .req_lane  (req_lane),
    .req_reg   (req_reg),
    .rsp_valid (rsp_valid),
    .rsp_n     (rsp_n),
    .rsp_m     (rsp_m)
);

// File: tb/sim_xor_basis_mapper.sv
module sim_xor_basis_mapper;
    import xbm_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                 rst;
    logic                 cfg_we;
    logic [1:0]           cfg_dim;
    logic [BIT_IDX_W-1:0] cfg_bit;
    logic [7:0]           cfg_n, cfg_m;
    logic                 req_valid;
    logic [1:0]           req_warp;
    logic [5:0]           req_lane;
    logic [1:0]           req_reg;
    logic                 rsp_valid;
    logic [7:0]           rsp_n, rsp_m;

    xor_basis_mapper u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dim(cfg_dim),
        .cfg_bit(cfg_bit), .cfg_n(cfg_n), .cfg_m(cfg_m),
        .req_valid(req_valid), .req_warp(req_warp), .req_lane(req_lane),
        .req_reg(req_reg), .rsp_valid(rsp_valid), .rsp_n(rsp_n), .rsp_m(rsp_m)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected-result queue
    logic [7:0] exp_n [256];
    logic [7:0] exp_m [256];
    int         exp_cyc [256];
    string      exp_tag [256];
    int         wr_p = 0;
    int         rd_p = 0;

    // Reference basis table, index: reg 0..1, lane 2..7, warp 8..9
    logic [7:0] bm_n [10];
    logic [7:0] bm_m [10];

    task automatic reset_model();
        bm_n = '{8'd0, 8'd0, 8'd1, 8'd2, 8'd4, 8'd8, 8'd0, 8'd0, 8'd0, 8'd0};
        bm_m = '{8'd1, 8'd2, 8'd0, 8'd0, 8'd0, 8'd0, 8'd4, 8'd8, 8'd0, 8'd0};
    endtask

    function automatic void model(input logic [9:0] loc, output logic [7:0] n, output logic [7:0] m);
        n = 8'd0;
        m = 8'd0;
        for (int i = 0; i < 10; i++) begin
            if (loc[i]) begin
                n = n ^ bm_n[i];
                m = m ^ bm_m[i];
            end
        end
    endfunction

    task automatic model_write(input logic [1:0] dim, input logic [2:0] bt, input logic [7:0] wn, input logic [7:0] wm);
        int idx;
        idx = -1;
        if (dim == 2'd0 && bt < 3'd2) idx = int'(bt);
        if (dim == 2'd1 && bt < 3'd6) idx = 2 + int'(bt);
        if (dim == 2'd2 && bt < 3'd2) idx = 8 + int'(bt);
        if (idx >= 0) begin
            bm_n[idx] = wn;
            bm_m[idx] = wm;
        end
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // One cycle of stimulus. With use_lit the expected result is given,
    // otherwise it comes from the reference table before this cycle's write.
    task automatic step(input logic we, input logic [1:0] dim, input logic [2:0] bt,
                        input logic [7:0] wn, input logic [7:0] wm,
                        input logic v, input logic [9:0] loc,
                        input logic use_lit, input logic [7:0] ln, input logic [7:0] lm,
                        input string tag);
        logic [7:0] en, em;
        @(negedge clk);
        if (v) begin
            if (use_lit) begin
                en = ln;
                em = lm;
            end else begin
                model(loc, en, em);
            end
            exp_n[wr_p]   = en;
            exp_m[wr_p]   = em;
            exp_cyc[wr_p] = cyc;
            exp_tag[wr_p] = tag;
            wr_p++;
        end
        if (we) model_write(dim, bt, wn, wm);
        cfg_we    = we;
        cfg_dim   = dim;
        cfg_bit   = bt;
        cfg_n     = wn;
        cfg_m     = wm;
        req_valid = v;
        req_warp  = loc[9:8];
        req_lane  = loc[7:2];
        req_reg   = loc[1:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b0, 10'd0, 1'b0, 8'd0, 8'd0, "");
    endtask

    task automatic cfg(input logic [1:0] dim, input logic [2:0] bt, input logic [7:0] wn, input logic [7:0] wm);
        step(1'b1, dim, bt, wn, wm, 1'b0, 10'd0, 1'b0, 8'd0, 8'd0, "");
    endtask

    task automatic look(input logic [1:0] w, input logic [5:0] t, input logic [1:0] r, input string tag);
        step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, {w, t, r}, 1'b0, 8'd0, 8'd0, tag);
    endtask

    // Response monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (rd_p >= wr_p) begin
                checks++;
                errors++;
                $display("FAIL R7 unexpected response: actual=1 expected=0");
            end else begin
                check(exp_tag[rd_p], "n", 32'(rsp_n), 32'(exp_n[rd_p]));
                check(exp_tag[rd_p], "m", 32'(rsp_m), 32'(exp_m[rd_p]));
                check("R7", "latency", 32'(cyc - exp_cyc[rd_p]), 32'd2);
                rd_p++;
            end
        end
    end

    // Vectors under the reset layout: {warp, lane, reg, n, m}
    localparam logic [25:0] VEC [8] = '{
        {2'd0, 6'd0,  2'd0, 8'd0,  8'd0},
        {2'd0, 6'd5,  2'd3, 8'd5,  8'd3},
        {2'd0, 6'd17, 2'd1, 8'd1,  8'd5},
        {2'd1, 6'd47, 2'd2, 8'd15, 8'd10},
        {2'd3, 6'd63, 2'd3, 8'd15, 8'd15},
        {2'd2, 6'd32, 2'd0, 8'd0,  8'd8},
        {2'd0, 6'd16, 2'd0, 8'd0,  8'd4},
        {2'd0, 6'd10, 2'd2, 8'd10, 8'd2}
    };

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] last_n, last_m;
        rst = 1'b1;
        cfg_we = 1'b0; cfg_dim = 2'd0; cfg_bit = '0; cfg_n = 8'd0; cfg_m = 8'd0;
        req_valid = 1'b0; req_warp = 2'd0; req_lane = 6'd0; req_reg = 2'd0;
        reset_model();
        repeat (3) @(negedge clk);
        // R10: outputs cleared in reset
        check("R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        check("R10", "rsp_n in reset", 32'(rsp_n), 32'd0);
        check("R10", "rsp_m in reset", 32'(rsp_m), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1, R3, R7: reset layout, back-to-back requests
        for (int i = 0; i < 8; i++)
            step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, VEC[i][25:16], 1'b1,
                 VEC[i][15:8], VEC[i][7:0], "R1");
        idle(4);

        // R4, R11: rewrite bases with full-width values
        cfg(2'd1, 3'd5, 8'hFF, 8'h80);
        cfg(2'd2, 3'd1, 8'h3C, 8'h5A);
        cfg(2'd0, 3'd1, 8'h01, 8'h00);
        look(2'd2, 6'd32, 2'd0, "R11");
        look(2'd0, 6'd32, 2'd0, "R4");
        // R2: combinations of several set bits
        look(2'd3, 6'd63, 2'd3, "R2");
        look(2'd2, 6'd41, 2'd2, "R2");
        look(2'd0, 6'd0,  2'd0, "R3");
        idle(4);

        // R5: write and lookup of the same basis on one edge
        step(1'b1, 2'd0, 3'd0, 8'h11, 8'h22, 1'b1, {2'd0, 6'd0, 2'd1}, 1'b1, 8'h00, 8'h01, "R5");
        step(1'b0, 2'd0, 3'd0, 8'h00, 8'h00, 1'b1, {2'd0, 6'd0, 2'd1}, 1'b1, 8'h11, 8'h22, "R5");
        idle(4);

        // R6: writes to nonexistent fields or bits
        cfg(2'd3, 3'd0, 8'hAA, 8'hAA);
        cfg(2'd0, 3'd2, 8'hBB, 8'hBB);
        cfg(2'd2, 3'd5, 8'hCC, 8'hCC);
        cfg(2'd1, 3'd6, 8'hDD, 8'hDD);
        step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, {2'd0, 6'd1, 2'd0}, 1'b1, 8'h01, 8'h00, "R6");
        step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, {2'd1, 6'd0, 2'd0}, 1'b1, 8'h00, 8'h00, "R6");
        look(2'd3, 6'd63, 2'd3, "R6");
        idle(4);

        // R9: zero basis broadcasts
        cfg(2'd1, 3'd0, 8'h00, 8'h00);
        step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, {2'd0, 6'd6, 2'd0}, 1'b1, 8'h06, 8'h00, "R9");
        step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, {2'd0, 6'd7, 2'd0}, 1'b1, 8'h06, 8'h00, "R9");
        step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, {2'd1, 6'd7, 2'd0}, 1'b1, 8'h06, 8'h00, "R9");
        idle(4);

        // R8: outputs hold while no result is valid
        last_n = exp_n[wr_p-1];
        last_m = exp_m[wr_p-1];
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8", "rsp_valid idle", 32'(rsp_valid), 32'd0);
            check("R8", "rsp_n hold", 32'(rsp_n), 32'(last_n));
            check("R8", "rsp_m hold", 32'(rsp_m), 32'(last_m));
        end

        // R10: reset mid-run restores the layout and clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R10", "rsp_n after reset", 32'(rsp_n), 32'd0);
        rst = 1'b0;
        reset_model();
        step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, {2'd0, 6'd17, 2'd1}, 1'b1, 8'h01, 8'h05, "R10");
        step(1'b0, 2'd0, 3'd0, 8'd0, 8'd0, 1'b1, {2'd0, 6'd0,  2'd1}, 1'b1, 8'h00, 8'h01, "R10");
        idle(5);

        // R7: every request answered exactly once
        check("R7", "responses", 32'(rd_p), 32'(wr_p));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule